// File: doc/BRIEF.md
# Infrared Run-Length Expander and Carrier Modulator

This block drains bytes from a transmit queue and drives a single infrared emitter line. Each byte is expanded into a sequence of bit times. In plain mode the byte is shifted out as eight data bits. In run-length mode the byte describes one run of identical bits: the top bit gives the value and the low seven bits give the run length minus one.

A logic-1 bit keeps the emitter dark for its whole bit time. A logic-0 bit is filled with carrier pulses. A two-bit pulse-mode selector chooses between three fills: carrier for the whole bit time, exactly eight pulses, or exactly six pulses. Two divisors set the bit time and the carrier period in clock cycles.

The upstream queue offers bytes through a valid/ready handshake. The block takes a new byte only once the previous byte has been fully sent. The mode, pulse selection and both divisors are captured together with each byte.

Top module: `ir_tx_modulator`

## Requirements
- R1: After a synchronous reset `ir_out` and `busy` are 0 and `in_ready` is 1.
- R2: A byte is taken on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `in_ready` is 0 and `busy` is 1.
- R3: With `rle_en` = 0 a byte is sent as 8 bits, least significant bit first, each lasting `bit_div` cycles. The output for cycle k of the stream (k = 0 is the cycle after acceptance) appears on `ir_out` one cycle later.
- R4: With `rle_en` = 1 a byte sends a single run. Bit 7 is the run value and bits 6:0 hold the length minus 1, which gives 1 to 128 bit times.
- R5: During a logic-1 bit time `ir_out` stays 0 for every cycle.
- R6: With `pulse_mode` = 00, a logic-0 bit time carries a carrier of period `car_div` cycles. Each period is high for floor(`car_div`/2) cycles and then low, and the carrier phase restarts at the start of every bit time.
- R7: With `pulse_mode` = 01, a logic-0 bit carries exactly the first 8 carrier pulses of R6 and is low for the rest of its bit time.
- R8: With `pulse_mode` = 10, a logic-0 bit carries exactly the first 6 carrier pulses of R6 and is low for the rest of its bit time.
- R9: `pulse_mode` = 11 gives the same output as 00.
- R10: `in_ready` returns to 1, and `busy` to 0, only in the cycle after the last bit's final cycle. When no byte is pending, `ir_out` is 0.
- R11: `rle_en`, `pulse_mode`, `bit_div` and `car_div` are captured when a byte is accepted. Changing them while that byte is sent has no effect on its output. Divisor values below 2 are treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Byte from the transmit queue |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Block can accept a byte |
| rle_en | input | 1 | 1 selects the run-length byte format |
| pulse_mode | input | 2 | 00 continuous, 01 eight pulses, 10 six pulses, 11 as 00 |
| bit_div | input | BIT_DIV_W | Bit time in clock cycles |
| car_div | input | CAR_DIV_W | Carrier period in clock cycles |
| ir_out | output | 1 | Modulated emitter drive |
| busy | output | 1 | A byte is being sent |

## Verification
The bench compares `ir_out` cycle by cycle against a waveform it computes from the requirements for each scenario. A design that did not restart the carrier phase at each bit boundary would drift when the bit time is not a multiple of the carrier period. One that miscounted pulses would emit a seventh or ninth pulse, or cut the burst short. The run-length extremes are covered: a 128-bit run of zeros and a 128-bit run of ones. A run-length count that was off by one would end the byte a bit time early or late, and `in_ready` would then rise in the wrong cycle. Reserved pulse mode 11, an odd carrier period, and changes to the inputs during a byte are also exercised. A design that read its settings live would change the waveform partway through the byte.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

  typedef enum logic [1:0] {
    PM_CONT  = 2'b00,
    PM_EIGHT = 2'b01,
    PM_SIX   = 2'b10,
    PM_RSVD  = 2'b11
  } pulse_mode_e;

  localparam int PCNT_W = 4;

  // Pulse budget per logic-0 bit; zero means unlimited.
  function automatic logic [PCNT_W-1:0] pulse_cap(pulse_mode_e m);
    case (m)
      PM_EIGHT: pulse_cap = PCNT_W'(8);
      PM_SIX:   pulse_cap = PCNT_W'(6);
      default:  pulse_cap = '0;
    endcase
  endfunction

endpackage

// File: rtl/ir_run_feeder.sv
module ir_run_feeder
  import ir_tx_pkg::*;
#(
  parameter int BIT_DIV_W = 16,
  parameter int CAR_DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [7:0]           in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 rle_en,
  input  logic [1:0]           pulse_mode,
  input  logic [BIT_DIV_W-1:0] bit_div,
  input  logic [CAR_DIV_W-1:0] car_div,
  output logic                 active,
  output logic                 bit_val,
  output logic                 bit_restart,
  output pulse_mode_e          mode_q,
  output logic [CAR_DIV_W-1:0] cdiv_q
);

  localparam int RUN_W = 7;

  logic [BIT_DIV_W-1:0] bdiv_q;
  logic [BIT_DIV_W-1:0] cyc;
  logic [RUN_W-1:0]     remaining;
  logic [6:0]           shreg;
  logic                 rle_q;
  logic                 accept;
  logic                 bit_end;
  logic [BIT_DIV_W-1:0] bdiv_in;
  logic [CAR_DIV_W-1:0] cdiv_in;

  assign in_ready    = !active;
  assign accept      = in_valid && in_ready;
  assign bit_end     = active && (cyc == bdiv_q - BIT_DIV_W'(1));
  assign bit_restart = accept || bit_end;
  assign bdiv_in     = (bit_div < BIT_DIV_W'(2)) ? BIT_DIV_W'(2) : bit_div;
  assign cdiv_in     = (car_div < CAR_DIV_W'(2)) ? CAR_DIV_W'(2) : car_div;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      cyc       <= '0;
      remaining <= '0;
      shreg     <= '0;
      bit_val   <= 1'b1;
      rle_q     <= 1'b0;
      mode_q    <= PM_CONT;
      bdiv_q    <= BIT_DIV_W'(2);
      cdiv_q    <= CAR_DIV_W'(2);
    end else if (accept) begin
      active <= 1'b1;
      cyc    <= '0;
      rle_q  <= rle_en;
      mode_q <= pulse_mode_e'(pulse_mode);
      bdiv_q <= bdiv_in;
      cdiv_q <= cdiv_in;
      if (rle_en) begin
        bit_val   <= in_data[7];
        remaining <= in_data[6:0];
        shreg     <= '0;
      end else begin
        bit_val   <= in_data[0];
        remaining <= RUN_W'(7);
        shreg     <= in_data[7:1];
      end
    end else if (active) begin
      if (bit_end) begin
        cyc <= '0;
        if (remaining == '0) begin
          active <= 1'b0;
        end else begin
          remaining <= remaining - RUN_W'(1);
          if (!rle_q) begin
            bit_val <= shreg[0];
            shreg   <= {1'b0, shreg[6:1]};
          end
        end
      end else begin
        cyc <= cyc + BIT_DIV_W'(1);
      end
    end
  end

  // R2
  accept_takes_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (active && !in_ready));

  // R4
  run_value_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (active && rle_q && $past(active)) |-> $stable(bit_val));

  // R3
  plain_bit_budget_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !rle_q) |-> (remaining <= RUN_W'(7)));

  // R11
  settings_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> ($stable(mode_q) && $stable(cdiv_q) && $stable(bdiv_q)));

endmodule

// File: rtl/ir_carrier_shaper.sv
module ir_carrier_shaper
  import ir_tx_pkg::*;
#(
  parameter int CAR_DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 active,
  input  logic                 bit_val,
  input  logic                 restart,
  input  pulse_mode_e          mode,
  input  logic [CAR_DIV_W-1:0] cdiv,
  output logic                 ir_out
);

  logic [CAR_DIV_W-1:0] ph;
  logic [PCNT_W-1:0]    pc;
  logic [CAR_DIV_W-1:0] half;
  logic [PCNT_W-1:0]    cap;
  logic                 budget_ok;

  assign half      = cdiv >> 1;
  assign cap       = pulse_cap(mode);
  assign budget_ok = (cap == '0) || (pc < cap);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      pc     <= '0;
      ir_out <= 1'b0;
    end else begin
      if (restart) begin
        ph <= '0;
        pc <= '0;
      end else if (ph == cdiv - CAR_DIV_W'(1)) begin
        ph <= '0;
        if (pc != {PCNT_W{1'b1}}) pc <= pc + PCNT_W'(1);
      end else begin
        ph <= ph + CAR_DIV_W'(1);
      end
      ir_out <= active && !bit_val && (ph < half) && budget_ok;
    end
  end

  // R10
  idle_dark_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> !ir_out);

  // R5
  one_bit_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (active && bit_val) |=> !ir_out);

  // R7
  eight_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_EIGHT && pc >= PCNT_W'(8)) |=> !ir_out);

  // R8
  six_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_SIX && pc >= PCNT_W'(6)) |=> !ir_out);

endmodule

// File: rtl/ir_tx_modulator.sv
module ir_tx_modulator
  import ir_tx_pkg::*;
#(
  parameter int BIT_DIV_W = 16,
  parameter int CAR_DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [7:0]           in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 rle_en,
  input  logic [1:0]           pulse_mode,
  input  logic [BIT_DIV_W-1:0] bit_div,
  input  logic [CAR_DIV_W-1:0] car_div,
  output logic                 ir_out,
  output logic                 busy
);

  logic                 active;
  logic                 bit_val;
  logic                 bit_restart;
  pulse_mode_e          mode_q;
  logic [CAR_DIV_W-1:0] cdiv_q;

  ir_run_feeder #(
    .BIT_DIV_W(BIT_DIV_W),
    .CAR_DIV_W(CAR_DIV_W)
  ) u_feeder (
    .clk        (clk),
    .rst        (rst),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .rle_en     (rle_en),
    .pulse_mode (pulse_mode),
    .bit_div    (bit_div),
    .car_div    (car_div),
    .active     (active),
    .bit_val    (bit_val),
    .bit_restart(bit_restart),
    .mode_q     (mode_q),
    .cdiv_q     (cdiv_q)
  );

  ir_carrier_shaper #(
    .CAR_DIV_W(CAR_DIV_W)
  ) u_shaper (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .bit_val(bit_val),
    .restart(bit_restart),
    .mode   (mode_q),
    .cdiv   (cdiv_q),
    .ir_out (ir_out)
  );

  assign busy = active;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!ir_out && !busy && in_ready));

  // R10
  ready_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> in_ready);

endmodule

// File: tb/ir_tx_modulator_bench.sv
module ir_tx_modulator_bench;

  localparam int BDW = 16;
  localparam int CDW = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [7:0]     in_data = '0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic           rle_en = 1'b0;
  logic [1:0]     pulse_mode = 2'b00;
  logic [BDW-1:0] bit_div = BDW'(8);
  logic [CDW-1:0] car_div = CDW'(4);
  logic           ir_out;
  logic           busy;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ir_tx_modulator #(.BIT_DIV_W(BDW), .CAR_DIV_W(CDW)) u_ir_tx_modulator (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .rle_en(rle_en), .pulse_mode(pulse_mode),
    .bit_div(bit_div), .car_div(car_div), .ir_out(ir_out), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_out(input logic [7:0] d, input bit rle, input int mode,
                                    input int bdiv, input int cdiv, input int k);
    int b = k / bdiv;
    int c = k % bdiv;
    int ph = c % cdiv;
    int pc = c / cdiv;
    int cap = (mode == 1) ? 8 : (mode == 2) ? 6 : 0;
    bit v = rle ? d[7] : d[b];
    if (v) return 0;
    if (ph >= cdiv / 2) return 0;
    if (cap != 0 && pc >= cap) return 0;
    return 1;
  endfunction

  // Sends one byte and checks the whole waveform, handshake and idle afterwards.
  task automatic send_byte(input string req, input logic [7:0] d, input bit rle,
                           input int mode, input int bdiv, input int cdiv, input bit disturb);
    int n = rle ? (int'(d[6:0]) + 1) : 8;
    int total = n * bdiv;
    int bad = 0;
    int first_k = -1;
    int first_act = 0;
    int first_exp = 0;
    @(negedge clk);
    check({req, " ready before offer"}, int'(in_ready), 1);
    in_data = d; rle_en = rle; pulse_mode = mode[1:0];
    bit_div = BDW'(bdiv); car_div = CDW'(cdiv); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (disturb) begin
      rle_en = ~rle; pulse_mode = mode[1:0] ^ 2'b01;
      bit_div = BDW'(bdiv + 3); car_div = CDW'(cdiv + 1); in_data = ~d;
    end
    check("R2 ready low after accept", int'(in_ready), 0);
    check("R2 busy after accept", int'(busy), 1);
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      begin
        int e = expect_out(d, rle, mode, bdiv, cdiv, k);
        if (int'(ir_out) != e) begin
          bad++;
          if (first_k < 0) begin first_k = k; first_act = int'(ir_out); first_exp = e; end
        end
      end
      if (k == total - 2) check("R10 ready held during last bit", int'(in_ready), 0);
      if (k == total - 1) begin
        check("R10 ready after last bit", int'(in_ready), 1);
        check("R10 busy clear after last bit", int'(busy), 0);
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: waveform cycle %0d actual %0d expected %0d (%0d bad cycles)",
               req, first_k, first_act, first_exp, bad);
    end
    @(negedge clk);
    check("R10 idle output low", int'(ir_out), 0);
  endtask

  task automatic t_reset();
    check("R1 ir_out in reset", int'(ir_out), 0);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 ready in reset", int'(in_ready), 1);
  endtask

  task automatic t_plain();
    send_byte("R3 R6 plain A5 continuous", 8'hA5, 1'b0, 0, 12, 4, 1'b0);
    send_byte("R3 R6 plain 3C odd carrier", 8'h3C, 1'b0, 0, 11, 5, 1'b0);
  endtask

  task automatic t_pulse_counts();
    send_byte("R7 eight pulses", 8'h05, 1'b1, 1, 40, 4, 1'b0);
    send_byte("R8 six pulses", 8'h02, 1'b1, 2, 40, 4, 1'b0);
    send_byte("R7 R3 plain eight pulses", 8'h96, 1'b0, 1, 38, 4, 1'b0);
  endtask

  task automatic t_reserved();
    send_byte("R9 mode 11 continuous", 8'h03, 1'b1, 3, 40, 6, 1'b0);
  endtask

  task automatic t_run_extremes();
    send_byte("R4 R5 run of 128 ones", 8'hFF, 1'b1, 0, 4, 2, 1'b0);
    send_byte("R4 run of 128 zeros", 8'h7F, 1'b1, 2, 4, 2, 1'b0);
    send_byte("R4 single bit run", 8'h00, 1'b1, 0, 6, 2, 1'b0);
  endtask

  task automatic t_settings_captured();
    send_byte("R11 inputs changed mid byte", 8'h5A, 1'b0, 2, 30, 4, 1'b1);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_plain();
    t_pulse_counts();
    t_reserved();
    t_run_extremes();
    t_settings_captured();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule